// File: doc/BRIEF.md
# Most-Frequently-Used Page Frame Replacement Controller

This block tracks which virtual pages currently occupy a small set of physical page frames and decides, on every reference, whether the page is already resident or must be brought in. When a page must come in and no frame is free, the block gives up the resident page that has been referenced most often. If several pages share that top count, the one that has been resident longest goes. The block moves no data and translates no addresses. It only makes the placement decision and reports it, so that a paging engine around it can act.

References arrive one per cycle on a valid/ready request port. Each accepted reference produces a registered response one cycle later. The response gives the hit or fault outcome, the frame index used and, when a resident page had to be displaced, that page's number. Each frame holds a saturating reference count and a rank for its load order. A running fault count is always visible.

Top module: `mfu_pager`

## Requirements
- R1: `req_ready_o` is high whenever reset is not active. An accepted reference causes `rsp_valid_o` to be high in the following cycle, for exactly that cycle. A cycle without a request causes `rsp_valid_o` to be low in the following cycle.
- R2: A reference to a resident page is reported as a hit (`rsp_hit_o`=1, `rsp_evict_o`=0). `rsp_frame_o` then gives the frame holding that page, and no frame contents change.
- R3: A reference to a non-resident page while some frame is empty is a fault. The page goes into the lowest-numbered empty frame, and `rsp_evict_o` is 0.
- R4: A fault with every frame occupied replaces the resident page with the highest reference count. `rsp_evict_o` is 1, `rsp_victim_o` gives the displaced page and `rsp_frame_o` gives its frame.
- R5: Among pages tied at the highest count, the one loaded earliest is replaced.
- R6: A newly loaded page starts at count 1, including a page that was displaced earlier and comes back. Each hit adds 1 to the referenced page's count.
- R7: Load order changes only when a page is loaded. Hits never make a page count as more recently loaded.
- R8: Reference counts stop at 2^CNT_W-1 and do not wrap.
- R9: `fault_cnt_o` rises by exactly 1 in the response cycle of every fault, fills included, and holds in every other cycle.
- R10: Reset (`rst_ni` low) empties all frames, zeroes `fault_cnt_o` and clears `rsp_valid_o`.
- R11: With four frames, the reference string 1,2,3,4,5,3,4,1,6,7,8,7,8,9,7,8,9,5,4,5,4,2 gives 15 faults in total, 11 of which displace a resident page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Reference present |
| req_page_i | input | PAGE_W | Referenced page number |
| req_ready_o | output | 1 | Reference can be accepted |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Page was resident |
| rsp_frame_o | output | $clog2(NUM_FRAMES) | Frame holding the page after the reference |
| rsp_evict_o | output | 1 | A resident page was displaced |
| rsp_victim_o | output | PAGE_W | Displaced page, meaningful with rsp_evict_o |
| fault_cnt_o | output | FAULT_W | Running fault count |

## Verification
All response fields and `fault_cnt_o` are registered at the edge that accepts the reference. They are therefore due one clock edge after the request, and frame state updates at that same edge, so back-to-back references see each other's effect. The bench drives each request on the falling edge and compares every field on the next falling edge, against a reference model advanced at the moment of driving. Idle cycles and reset are checked at the same offset for a low `rsp_valid_o`. The tie-break, saturation and load-order cases are built as directed sequences whose victim differs under any wrong policy.

// File: rtl/mfu_pkg.sv
package mfu_pkg;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_HIT     = 2'd1,
    ACT_FILL    = 2'd2,
    ACT_REPLACE = 2'd3
  } act_e;

endpackage

// File: rtl/mfu_lookup.sv
module mfu_lookup #(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 8,
  localparam int FIDX_W    = $clog2(NUM_FRAMES)
) (
  input  logic [NUM_FRAMES-1:0]             vld_i,
  input  logic [NUM_FRAMES-1:0][PAGE_W-1:0] page_i,
  input  logic [PAGE_W-1:0]                 req_page_i,
  output logic                              hit_o,
  output logic [FIDX_W-1:0]                 hit_idx_o,
  output logic                              has_empty_o,
  output logic [FIDX_W-1:0]                 empty_idx_o
);

  logic [NUM_FRAMES-1:0] match;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
    assign match[g] = vld_i[g] && (page_i[g] == req_page_i);
  end

  assign hit_o       = |match;
  assign has_empty_o = ~&vld_i;

  // lowest index wins in both encoders
  always_comb begin
    hit_idx_o   = '0;
    empty_idx_o = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
      if (match[i])  hit_idx_o   = FIDX_W'(i);
      if (!vld_i[i]) empty_idx_o = FIDX_W'(i);
    end
  end

endmodule

// File: rtl/mfu_victim.sv
module mfu_victim #(
  parameter int NUM_FRAMES = 4,
  parameter int CNT_W      = 4,
  localparam int FIDX_W    = $clog2(NUM_FRAMES)
) (
  input  logic [NUM_FRAMES-1:0][CNT_W-1:0]  cnt_i,
  input  logic [NUM_FRAMES-1:0][FIDX_W-1:0] age_i,
  output logic [FIDX_W-1:0]                 vic_idx_o
);

  logic [NUM_FRAMES-1:0] beats_all;

  // frame i wins when it outranks every other: higher count, or equal count and older
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_rank
    always_comb begin
      beats_all[g] = 1'b1;
      for (int j = 0; j < NUM_FRAMES; j++) begin
        if (j != g) begin
          if (!((cnt_i[g] > cnt_i[j]) ||
                ((cnt_i[g] == cnt_i[j]) && (age_i[g] > age_i[j]))))
            beats_all[g] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    vic_idx_o = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--)
      if (beats_all[i]) vic_idx_o = FIDX_W'(i);
  end

endmodule

// File: rtl/mfu_frame_table.sv
module mfu_frame_table
  import mfu_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 8,
  parameter int CNT_W      = 4,
  localparam int FIDX_W    = $clog2(NUM_FRAMES),
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  act_e                              act_i,
  input  logic [FIDX_W-1:0]                 idx_i,
  input  logic [PAGE_W-1:0]                 page_i,
  output logic [NUM_FRAMES-1:0]             vld_o,
  output logic [NUM_FRAMES-1:0][PAGE_W-1:0] page_o,
  output logic [NUM_FRAMES-1:0][CNT_W-1:0]  cnt_o,
  output logic [NUM_FRAMES-1:0][FIDX_W-1:0] age_o
);

  logic [FIDX_W-1:0] tgt_age;
  logic              load;

  assign tgt_age = age_o[idx_i];
  assign load    = (act_i == ACT_FILL) || (act_i == ACT_REPLACE);

  // age is a rank among valid frames: 0 = newest; kept a permutation by
  // aging only the frames younger than the one being overwritten
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic sel;
    logic bump;
    assign sel  = (idx_i == FIDX_W'(g));
    assign bump = load && !sel && vld_o[g] &&
                  ((act_i == ACT_FILL) || (age_o[g] < tgt_age));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g]  <= 1'b0;
        page_o[g] <= '0;
        cnt_o[g]  <= '0;
        age_o[g]  <= '0;
      end else begin
        if (load && sel) begin
          vld_o[g]  <= 1'b1;
          page_o[g] <= page_i;
          cnt_o[g]  <= CNT_W'(1);
          age_o[g]  <= '0;
        end else if (bump) begin
          age_o[g] <= age_o[g] + 1'b1;
        end
        if (act_i == ACT_HIT && sel && cnt_o[g] != CNT_MAX)
          cnt_o[g] <= cnt_o[g] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mfu_pager.sv
module mfu_pager
  import mfu_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 8,
  parameter int CNT_W      = 4,
  parameter int FAULT_W    = 16,
  localparam int FIDX_W    = $clog2(NUM_FRAMES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [PAGE_W-1:0]  req_page_i,
  output logic               req_ready_o,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [FIDX_W-1:0]  rsp_frame_o,
  output logic               rsp_evict_o,
  output logic [PAGE_W-1:0]  rsp_victim_o,
  output logic [FAULT_W-1:0] fault_cnt_o
);

  logic [NUM_FRAMES-1:0]             frame_vld;
  logic [NUM_FRAMES-1:0][PAGE_W-1:0] frame_page;
  logic [NUM_FRAMES-1:0][CNT_W-1:0]  frame_cnt;
  logic [NUM_FRAMES-1:0][FIDX_W-1:0] frame_age;

  logic              hit, has_empty, fire;
  logic [FIDX_W-1:0] hit_idx, empty_idx, vic_idx, use_idx;
  act_e              act;

  assign req_ready_o = rst_ni;
  assign fire        = req_valid_i && req_ready_o;

  mfu_lookup #(.NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W)) u_lookup (
    .vld_i       (frame_vld),
    .page_i      (frame_page),
    .req_page_i  (req_page_i),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx),
    .has_empty_o (has_empty),
    .empty_idx_o (empty_idx)
  );

  mfu_victim #(.NUM_FRAMES(NUM_FRAMES), .CNT_W(CNT_W)) u_victim (
    .cnt_i     (frame_cnt),
    .age_i     (frame_age),
    .vic_idx_o (vic_idx)
  );

  always_comb begin
    act     = ACT_NONE;
    use_idx = hit_idx;
    if (fire) begin
      if (hit) begin
        act = ACT_HIT;
      end else if (has_empty) begin
        act     = ACT_FILL;
        use_idx = empty_idx;
      end else begin
        act     = ACT_REPLACE;
        use_idx = vic_idx;
      end
    end
  end

  mfu_frame_table #(.NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .idx_i  (use_idx),
    .page_i (req_page_i),
    .vld_o  (frame_vld),
    .page_o (frame_page),
    .cnt_o  (frame_cnt),
    .age_o  (frame_age)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_frame_o  <= '0;
      rsp_evict_o  <= 1'b0;
      rsp_victim_o <= '0;
      fault_cnt_o  <= '0;
    end else begin
      rsp_valid_o <= fire;
      if (fire) begin
        rsp_hit_o    <= (act == ACT_HIT);
        rsp_frame_o  <= use_idx;
        rsp_evict_o  <= (act == ACT_REPLACE);
        rsp_victim_o <= frame_page[use_idx];
        if (act != ACT_HIT) fault_cnt_o <= fault_cnt_o + 1'b1;
      end else begin
        rsp_evict_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mfu_pager_chk.sv
module mfu_pager_chk #(
  parameter int NUM_FRAMES = 4,
  parameter int FAULT_W    = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_ready_o,
  input logic                  rsp_valid_o,
  input logic                  rsp_hit_o,
  input logic                  rsp_evict_o,
  input logic [FAULT_W-1:0]    fault_cnt_o,
  input logic [NUM_FRAMES-1:0] frame_vld
);

  assert_rsp_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  assert_idle_no_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_hit_no_evict_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> !rsp_evict_o);

  assert_fill_adds_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o && !rsp_evict_o) |->
      ($countones(frame_vld) == $countones($past(frame_vld)) + 1));

  assert_evict_only_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_evict_o |-> (rsp_valid_o && (&$past(frame_vld))));

  assert_fault_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (fault_cnt_o == $past(fault_cnt_o) + 1'b1));

  assert_fault_count_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && !rsp_hit_o) |-> $stable(fault_cnt_o));

  assert_frames_never_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(frame_vld) >= $countones($past(frame_vld)));

endmodule

bind mfu_pager mfu_pager_chk #(.NUM_FRAMES(NUM_FRAMES), .FAULT_W(FAULT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_evict_o (rsp_evict_o),
  .fault_cnt_o (fault_cnt_o),
  .frame_vld   (frame_vld)
);

// File: tb/tb_mfu_pager.sv
`timescale 1ns/1ps
module tb_mfu_pager;

  localparam int NF      = 4;
  localparam int PW      = 8;
  localparam int CW      = 4;
  localparam int FW      = 16;
  localparam int FXW     = $clog2(NF);
  localparam int CNT_TOP = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic [PW-1:0]  req_page = '0;
  logic           req_ready, rsp_valid, rsp_hit, rsp_evict;
  logic [FXW-1:0] rsp_frame;
  logic [PW-1:0]  rsp_victim;
  logic [FW-1:0]  fault_cnt;

  always #5 clk = ~clk;

  mfu_pager #(.NUM_FRAMES(NF), .PAGE_W(PW), .CNT_W(CW), .FAULT_W(FW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_page_i(req_page),
    .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .rsp_frame_o(rsp_frame), .rsp_evict_o(rsp_evict), .rsp_victim_o(rsp_victim),
    .fault_cnt_o(fault_cnt)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model: load sequence numbers instead of ranks
  bit m_vld[NF];
  int m_page[NF], m_cnt[NF], m_seq[NF];
  int m_seq_ctr, m_faults, m_evicts;

  task automatic model_clear();
    for (int k = 0; k < NF; k++) begin
      m_vld[k] = 0; m_page[k] = 0; m_cnt[k] = 0; m_seq[k] = 0;
    end
    m_seq_ctr = 0; m_faults = 0; m_evicts = 0;
  endtask

  task automatic model_ref(input int pg, output bit hit, output int fr,
                           output bit ev, output int vic);
    int best;
    hit = 0; fr = -1; ev = 0; vic = 0;
    for (int k = 0; k < NF; k++)
      if (!hit && m_vld[k] && m_page[k] == pg) begin hit = 1; fr = k; end
    if (hit) begin
      if (m_cnt[fr] < CNT_TOP) m_cnt[fr]++;
    end else begin
      m_faults++;
      for (int k = NF - 1; k >= 0; k--) if (!m_vld[k]) fr = k;
      if (fr < 0) begin
        best = 0;
        for (int k = 1; k < NF; k++)
          if (m_cnt[k] > m_cnt[best] ||
              (m_cnt[k] == m_cnt[best] && m_seq[k] < m_seq[best])) best = k;
        fr = best; ev = 1; vic = m_page[best]; m_evicts++;
      end
      m_vld[fr] = 1; m_page[fr] = pg; m_cnt[fr] = 1; m_seq[fr] = m_seq_ctr++;
    end
  endtask

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // drive at falling edge, response due at next falling edge
  task automatic do_ref(input int pg, input string req);
    bit eh, ee; int ef, evp;
    req_valid = 1'b1; req_page = PW'(pg);
    model_ref(pg, eh, ef, ee, evp);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_hit == eh && int'(rsp_frame) == ef && rsp_evict == ee &&
          (!ee || int'(rsp_victim) == evp) && int'(fault_cnt) == m_faults, req,
          $sformatf("page %0d got v=%0b h=%0b f=%0d e=%0b vic=%0d fc=%0d exp v=1 h=%0b f=%0d e=%0b vic=%0d fc=%0d",
                    pg, rsp_valid, rsp_hit, rsp_frame, rsp_evict, rsp_victim, fault_cnt,
                    eh, ef, ee, evp, m_faults));
  endtask

  task automatic do_idle(input string req);
    req_valid = 1'b0;
    @(negedge clk);
    check(!rsp_valid && int'(fault_cnt) == m_faults, req,
          $sformatf("idle got v=%0b fc=%0d exp v=0 fc=%0d", rsp_valid, fault_cnt, m_faults));
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    check(!rsp_valid && fault_cnt == '0 && !req_ready, "R10",
          $sformatf("in reset got v=%0b fc=%0d rdy=%0b exp 0 0 0", rsp_valid, fault_cnt, req_ready));
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1", $sformatf("ready got %0b exp 1", req_ready));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seq[22] = '{1,2,3,4,5,3,4,1,6,7,8,7,8,9,7,8,9,5,4,5,4,2};
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();

    // R11: full reference string, fills R3, ties R5, hits R2/R6
    foreach (seq[i]) do_ref(seq[i], "R11");
    check(m_faults == 15 && int'(fault_cnt) == 15, "R11",
          $sformatf("faults got %0d exp 15", fault_cnt));
    check(m_evicts == 11, "R11", $sformatf("model evictions got %0d exp 11", m_evicts));
    do_idle("R1");

    // R7: hits in reverse load order must not refresh load order; 10 is oldest
    do_reset();
    do_ref(10, "R3"); do_ref(11, "R3"); do_ref(12, "R3"); do_ref(13, "R3");
    do_ref(13, "R2"); do_ref(12, "R2"); do_ref(11, "R2"); do_ref(10, "R7");
    do_ref(20, "R7");        // evicts 10
    do_ref(10, "R6");        // reloaded 10 at count 1; ties at 2 -> 11 oldest
    do_ref(21, "R5");

    // R4: highest count wins over older pages
    do_reset();
    do_ref(1, "R3"); do_ref(2, "R3"); do_ref(3, "R3"); do_ref(4, "R3");
    do_ref(4, "R6"); do_ref(4, "R6");
    do_ref(9, "R4");         // evicts 4 (count 3)

    // R8: page 30 hit 20 times saturates; 31 reaches max; tie -> 30 older
    do_reset();
    do_ref(30, "R3"); do_ref(31, "R3"); do_ref(32, "R3"); do_ref(33, "R3");
    for (int i = 0; i < 20; i++) do_ref(30, "R8");
    for (int i = 0; i < CNT_TOP - 1; i++) do_ref(31, "R8");
    do_ref(40, "R8");

    // mid-stream reset then reuse
    do_ref(31, "R2");
    do_reset();
    do_ref(31, "R10");

    // random traffic with idle gaps
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(3) == 0) do_idle("R1");
      else do_ref(int'($urandom_range(9)), "R4");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule